// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit processor and the ROM and battery RAM of a plug-in cartridge. The processor has a 16-bit address bus. The lower 32 KiB of that address space is read-only, so the block treats every processor write in that range as a write to one of its control latches. From those latches it forms a wide ROM address for the switchable 16 KiB window at 0x4000–0x7FFF, and a wide RAM address for the 8 KiB window at 0xA000–0xBFFF. The fixed window at 0x0000–0x3FFF always maps straight through.

A two-bit variant input chooses one of three controller personalities:

- **None.** There is no controller, so writes change nothing.
- **Small-bank.** It has a 7-bit ROM bank and a mode bit. The mode bit decides whether two latch bits extend the ROM bank or select the RAM bank.
- **Large-bank.** It has a 9-bit ROM bank, an 8-bit RAM bank and no zero remap.

The block also forms the read byte back to the processor. It returns 0xFF for a ROM bank that does not exist, and for RAM that is disabled or missing. When a clock option is strapped on, five RAM bank numbers select small clock registers instead of RAM. The ROM and RAM arrays themselves live outside the block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, the ROM bank is 1, the RAM bank is 0, RAM is disabled and the small-bank mode is ROM mode. A read at 0x4000 therefore returns the byte at ROM offset 0x4000, and a read in 0xA000–0xBFFF returns 0xFF.
- R2: For addresses 0x0000–0x3FFF, rom_addr_o equals the address (upper bits zero), and cpu_rdata_o equals rom_rdata_i. This holds in every variant.
- R3: Variant encoding is 2'b00 none, 2'b01 small-bank, 2'b10 large-bank, and 2'b11 acts as none. In small-bank and large-bank, a write to 0x0000–0x1FFF enables RAM when the data is exactly 0x0A. Any other data disables RAM.
- R4: A write to 0x2000–0x2FFF loads the low ROM bank bits. Small-bank keeps data bits 4:0 and turns 0 into 1, leaving bits 6:5 untouched. Large-bank loads bank bits 7:0 from the full byte, and 0 stays 0. In small-bank, 0x3000–0x3FFF acts the same as 0x2000–0x2FFF.
- R5: In large-bank, a write to 0x3000–0x3FFF loads ROM bank bit 8 from data bit 0.
- R6: In small-bank, a write to 0x4000–0x5FFF takes data bits 1:0. They become the RAM bank in RAM mode, or ROM bank bits 6:5 in ROM mode. In large-bank, the whole byte becomes the RAM bank.
- R7: In small-bank, a write to 0x6000–0x7FFF sets the mode from data bit 0 (1 = RAM mode). Entering RAM mode moves ROM bank bits 6:5 into the RAM bank and clears them. Leaving RAM mode moves RAM bank bits 1:0 back into ROM bits 6:5 and clears the RAM bank.
- R8: A read at 0x4000–0x7FFF uses ROM offset bank*0x4000 + addr[13:0]. If the bank is ROM_BANKS or higher, it returns 0xFF.
- R9: RAM uses offset bank*0x2000 + addr[12:0]. If RAM is disabled, or the bank is RAM_BANKS or higher, reads return 0xFF and ram_we_o stays low.
- R10: With has_clock_i high and the RAM bank in 8..12, accesses in 0xA000–0xBFFF go to clock register (bank−8) whether or not RAM is enabled. External RAM is not written. Register 4 reads with bits 5:1 forced to 1.
- R11: In the none variant, control writes change no state, and 0x4000–0x7FFF maps to bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| variant_i | input | 2 | Controller personality (see R3) |
| has_clock_i | input | 1 | Clock register option present |
| cpu_addr_i | input | 16 | Processor address |
| cpu_wr_i | input | 1 | Processor write strobe, one cycle per write |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Read byte returned to the processor |
| rom_addr_o | output | 23 | ROM byte offset |
| rom_rdata_i | input | 8 | Byte from the ROM array at rom_addr_o |
| ram_addr_o | output | 21 | External RAM byte offset |
| ram_we_o | output | 1 | External RAM write enable |
| ram_rdata_i | input | 8 | Byte from the RAM array at ram_addr_o |

## Verification
The assertions assume three things about the inputs:
- variant_i and has_clock_i are straps that change only while reset is held.
- Each processor write is a single-cycle strobe.
- The ROM and RAM arrays answer combinationally.

The bench applies each personality only inside a fresh reset. It pulses the write strobe for exactly one cycle and models both arrays as combinational lookups. Under these conditions, the frozen-state check for the none variant and the small-bank "bank never zero" check cannot be broken by a strap that changes mid-run.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int ROM_BANK_W = 9;
    localparam int RAM_BANK_W = 8;
    localparam int ROM_OFS_W  = 14;
    localparam int RAM_OFS_W  = 13;
    localparam int ROM_AW     = ROM_BANK_W + ROM_OFS_W;
    localparam int RAM_AW     = RAM_BANK_W + RAM_OFS_W;

    localparam int              CLK_REGS     = 5;
    localparam logic [7:0]      CLK_FIRST    = 8'h08;
    localparam logic [7:0]      CLK_HI_ONES  = 8'h3E;
    localparam logic [7:0]      EN_CODE      = 8'h0A;
    localparam logic [7:0]      OPEN_BUS     = 8'hFF;

    typedef enum logic [1:0] {
        VAR_NONE  = 2'b00,
        VAR_SMALL = 2'b01,
        VAR_LARGE = 2'b10,
        VAR_SPARE = 2'b11
    } variant_e;

    typedef struct packed {
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic                  ram_en;
        logic                  ram_mode;
    } bank_state_t;

endpackage

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
    import cbc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  variant_e    variant_i,
    input  logic        wr_i,
    input  logic [3:0]  addr_hi_i,
    input  logic [7:0]  wdata_i,
    output bank_state_t state_o
);

    bank_state_t st_d, st_q;
    logic [4:0]  low5_d;
    logic        active_d;

    always_comb begin
        st_d     = st_q;
        low5_d   = (wdata_i[4:0] == 5'd0) ? 5'd1 : wdata_i[4:0];
        active_d = (variant_i == VAR_SMALL) || (variant_i == VAR_LARGE);

        if (wr_i && !addr_hi_i[3] && active_d) begin
            unique case (addr_hi_i[2:1])
                2'b00: begin
                    st_d.ram_en = (wdata_i == EN_CODE);
                end
                2'b01: begin
                    if (variant_i == VAR_LARGE) begin
                        if (addr_hi_i[0]) st_d.rom_bank[8]   = wdata_i[0];
                        else              st_d.rom_bank[7:0] = wdata_i;
                    end else begin
                        st_d.rom_bank[4:0] = low5_d;
                    end
                end
                2'b10: begin
                    if (variant_i == VAR_LARGE) begin
                        st_d.ram_bank = wdata_i;
                    end else if (st_q.ram_mode) begin
                        st_d.ram_bank = {6'd0, wdata_i[1:0]};
                    end else begin
                        st_d.rom_bank[6:5] = wdata_i[1:0];
                    end
                end
                default: begin
                    if (variant_i == VAR_SMALL) begin
                        if (wdata_i[0] && !st_q.ram_mode) begin
                            st_d.ram_bank      = {6'd0, st_q.rom_bank[6:5]};
                            st_d.rom_bank[6:5] = 2'b00;
                        end else if (!wdata_i[0] && st_q.ram_mode) begin
                            st_d.rom_bank[6:5] = st_q.ram_bank[1:0];
                            st_d.ram_bank      = '0;
                        end
                        st_d.ram_mode = wdata_i[0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.rom_bank <= ROM_BANK_W'(1);
            st_q.ram_bank <= '0;
            st_q.ram_en   <= 1'b0;
            st_q.ram_mode <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/cbc_clock_regs.sv
module cbc_clock_regs
    import cbc_pkg::*;
#(
    parameter int NREGS = CLK_REGS
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       we_i,
    input  logic [2:0] idx_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o
);

    logic [7:0] regs_d [NREGS];
    logic [7:0] regs_q [NREGS];

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            localparam logic [7:0] ONES = (g == NREGS - 1) ? CLK_HI_ONES : 8'h00;

            always_comb begin
                regs_d[g] = regs_q[g];
                if (we_i && (idx_i == 3'(g))) regs_d[g] = wdata_i;
            end

            always_ff @(posedge clk_i) begin
                if (!rst_ni) regs_q[g] <= ONES;
                else         regs_q[g] <= regs_d[g] | ONES;
            end
        end
    endgenerate

    always_comb begin
        rdata_o = OPEN_BUS;
        for (int i = 0; i < NREGS; i++) begin
            if (idx_i == 3'(i)) rdata_o = regs_q[i];
        end
    end

endmodule

// File: rtl/cbc_read_map.sv
module cbc_read_map
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    parameter int RAM_BANKS = 4
) (
    input  logic [15:0]           addr_i,
    input  logic                  wr_i,
    input  logic                  has_clock_i,
    input  logic [ROM_BANK_W-1:0] rom_bank_i,
    input  logic [RAM_BANK_W-1:0] ram_bank_i,
    input  logic                  ram_en_i,
    input  logic [7:0]            rom_rdata_i,
    input  logic [7:0]            ram_rdata_i,
    input  logic [7:0]            clk_rdata_i,
    output logic [ROM_AW-1:0]     rom_addr_o,
    output logic [RAM_AW-1:0]     ram_addr_o,
    output logic                  ram_we_o,
    output logic                  clk_we_o,
    output logic [2:0]            clk_idx_o,
    output logic [7:0]            rdata_o
);

    localparam logic [ROM_BANK_W:0] ROM_LIMIT = (ROM_BANK_W + 1)'(ROM_BANKS);
    localparam logic [RAM_BANK_W:0] RAM_LIMIT = (RAM_BANK_W + 1)'(RAM_BANKS);
    localparam logic [7:0]          CLK_LAST  = CLK_FIRST + 8'(CLK_REGS - 1);

    logic in_lo, in_hi, in_ram;
    logic rom_ok, clk_sel, ram_ok;

    always_comb begin
        in_lo   = (addr_i[15:14] == 2'b00);
        in_hi   = (addr_i[15:14] == 2'b01);
        in_ram  = (addr_i[15:13] == 3'b101);
        rom_ok  = ({1'b0, rom_bank_i} < ROM_LIMIT);
        clk_sel = has_clock_i && (ram_bank_i >= CLK_FIRST) && (ram_bank_i <= CLK_LAST);
        ram_ok  = ram_en_i && ({1'b0, ram_bank_i} < RAM_LIMIT) && !clk_sel;

        rom_addr_o = in_hi ? {rom_bank_i, addr_i[13:0]} : {{ROM_BANK_W{1'b0}}, addr_i[13:0]};
        ram_addr_o = {ram_bank_i, addr_i[12:0]};
        // bank 8..12 maps to index 0..4 through its low three bits
        clk_idx_o  = ram_bank_i[2:0];
        ram_we_o   = wr_i && in_ram && ram_ok;
        clk_we_o   = wr_i && in_ram && clk_sel;

        if (in_lo)       rdata_o = rom_rdata_i;
        else if (in_hi)  rdata_o = rom_ok ? rom_rdata_i : OPEN_BUS;
        else if (in_ram) rdata_o = clk_sel ? clk_rdata_i : (ram_ok ? ram_rdata_i : OPEN_BUS);
        else             rdata_o = OPEN_BUS;
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    parameter int RAM_BANKS = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        variant_i,
    input  logic              has_clock_i,
    input  logic [15:0]       cpu_addr_i,
    input  logic              cpu_wr_i,
    input  logic [7:0]        cpu_wdata_i,
    output logic [7:0]        cpu_rdata_o,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [7:0]        rom_rdata_i,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic              ram_we_o,
    input  logic [7:0]        ram_rdata_i
);

    variant_e    variant;
    bank_state_t bank_q;
    logic        clk_we;
    logic [2:0]  clk_idx;
    logic [7:0]  clk_rdata;

    assign variant = variant_e'(variant_i);

    cbc_bank_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .variant_i (variant),
        .wr_i      (cpu_wr_i),
        .addr_hi_i (cpu_addr_i[15:12]),
        .wdata_i   (cpu_wdata_i),
        .state_o   (bank_q)
    );

    cbc_clock_regs #(.NREGS(CLK_REGS)) u_clk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (clk_we),
        .idx_i   (clk_idx),
        .wdata_i (cpu_wdata_i),
        .rdata_o (clk_rdata)
    );

    cbc_read_map #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_map (
        .addr_i      (cpu_addr_i),
        .wr_i        (cpu_wr_i),
        .has_clock_i (has_clock_i),
        .rom_bank_i  (bank_q.rom_bank),
        .ram_bank_i  (bank_q.ram_bank),
        .ram_en_i    (bank_q.ram_en),
        .rom_rdata_i (rom_rdata_i),
        .ram_rdata_i (ram_rdata_i),
        .clk_rdata_i (clk_rdata),
        .rom_addr_o  (rom_addr_o),
        .ram_addr_o  (ram_addr_o),
        .ram_we_o    (ram_we_o),
        .clk_we_o    (clk_we),
        .clk_idx_o   (clk_idx),
        .rdata_o     (cpu_rdata_o)
    );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        variant,
    input logic              has_clock,
    input logic [15:0]       addr,
    input logic              wr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_we,
    input bank_state_t       st
);

    localparam logic [ROM_BANK_W:0] ROM_LIMIT = (ROM_BANK_W + 1)'(ROM_BANKS);

    logic active;
    assign active = (variant == 2'b01) || (variant == 2'b10);

    assert_rom_low_linear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:14] == 2'b00) |-> (rom_addr == {7'd0, addr}));

    assert_enable_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr && addr[15:13] == 3'b000 && wdata == 8'h0A) |=> st.ram_en);

    assert_disable_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr && addr[15:13] == 3'b000 && wdata != 8'h0A) |=> !st.ram_en);

    assert_small_never_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (variant == 2'b01) |-> (st.rom_bank[4:0] != 5'd0));

    assert_rom_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:14] == 2'b01 && {1'b0, st.rom_bank} >= ROM_LIMIT) |-> (rdata == 8'hFF));

    assert_ram_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !st.ram_en |-> !ram_we);

    assert_clock_high_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (has_clock && st.ram_bank == 8'd12 && addr[15:13] == 3'b101) |-> (rdata[5:1] == 5'h1F));

    assert_none_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && wr) |=> ($stable(st.rom_bank) && $stable(st.ram_bank) && $stable(st.ram_en)));

endmodule

bind cart_bank_ctrl cbc_checker #(.ROM_BANKS(ROM_BANKS)) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .variant   (variant_i),
    .has_clock (has_clock_i),
    .addr      (cpu_addr_i),
    .wr        (cpu_wr_i),
    .wdata     (cpu_wdata_i),
    .rdata     (cpu_rdata_o),
    .rom_addr  (rom_addr_o),
    .ram_we    (ram_we_o),
    .st        (bank_q)
);

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;

    localparam int ROM_BANKS = 64;
    localparam int RAM_BANKS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  variant = 2'b01;
    logic        has_clock = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [22:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic [20:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_rdata;
    logic [7:0]  ram_mem [64];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .variant_i   (variant),
        .has_clock_i (has_clock),
        .cpu_addr_i  (addr),
        .cpu_wr_i    (wr),
        .cpu_wdata_i (wdata),
        .cpu_rdata_o (rdata),
        .rom_addr_o  (rom_addr),
        .rom_rdata_i (rom_rdata),
        .ram_addr_o  (ram_addr),
        .ram_we_o    (ram_we),
        .ram_rdata_i (ram_rdata)
    );

    function automatic logic [7:0] rom_pat(input logic [22:0] o);
        return o[7:0] ^ o[21:14] ^ {7'd0, o[22]};
    endfunction

    function automatic logic [7:0] exp_rom(input int bank, input logic [15:0] a);
        logic [8:0] b9;
        b9 = 9'(bank);
        if (bank >= ROM_BANKS) return 8'hFF;
        return rom_pat({b9, a[13:0]});
    endfunction

    assign rom_rdata = rom_pat(rom_addr);
    assign ram_rdata = ram_mem[{ram_addr[14:13], ram_addr[3:0]}];

    always @(posedge clk) begin
        if (ram_we) ram_mem[{ram_addr[14:13], ram_addr[3:0]}] <= wdata;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; wr = 1'b0;
        #1;
        v = rdata;
    endtask

    task automatic restart(input logic [1:0] v, input logic hc);
        @(negedge clk);
        rst_n = 1'b0; variant = v; has_clock = hc; wr = 1'b0;
        for (int i = 0; i < 64; i++) ram_mem[i] = 8'(i) ^ 8'hA5;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;

        // ---------------- small-bank variant ----------------
        restart(2'b01, 1'b0);
        do_rd(16'h4000, v); check("R1 rom bank after reset", v, exp_rom(1, 16'h4000));
        do_rd(16'hA000, v); check("R1 ram disabled after reset", v, 8'hFF);
        do_rd(16'h1234, v); check("R2 fixed window data", v, rom_pat(23'h1234));
        check("R2 fixed window address", rom_addr, 23'h1234);
        do_rd(16'h3FFF, v); check("R2 fixed window top", v, rom_pat(23'h3FFF));

        // sweep: upper two bits x low five bits, 0x3000 used for odd values
        for (int u = 0; u < 4; u++) begin
            do_wr(16'h4000, 8'(u));
            for (int l = 0; l < 32; l++) begin
                int bank;
                logic [15:0] ra;
                do_wr((l % 2 == 1) ? 16'h3000 : 16'h2000, 8'(l) | 8'hE0);
                bank = u * 32 + ((l == 0) ? 1 : l);
                ra = 16'h4000 + 16'(l * 257);
                do_rd(ra, v);
                check("R4 R6 R8 small bank sweep", v, exp_rom(bank, ra));
            end
        end

        // RAM enable latch
        do_wr(16'h4000, 8'h00);
        do_wr(16'h0000, 8'h0A);
        do_wr(16'hA003, 8'h5C);
        do_rd(16'hA003, v); check("R3 enabled ram readback", v, 8'h5C);
        do_wr(16'h1FFF, 8'h0B);
        do_rd(16'hA003, v); check("R3 non-code value disables", v, 8'hFF);
        do_wr(16'hA003, 8'h11);
        do_wr(16'h1000, 8'h0A);
        do_rd(16'hA003, v); check("R9 write while disabled ignored", v, 8'h5C);

        // mode switching
        do_wr(16'h4000, 8'h02);
        do_wr(16'h2000, 8'h03);
        do_rd(16'h4000, v); check("R8 bank 0x43 out of range", v, 8'hFF);
        do_wr(16'h6000, 8'h01);
        do_rd(16'h4000, v); check("R7 entering ram mode clears rom upper", v, exp_rom(3, 16'h4000));
        do_wr(16'hA001, 8'h77);
        do_rd(16'hA001, v); check("R7 ram bank 2 after move", v, 8'h77);
        check("R9 ram offset bank 2", ram_addr, 21'h4001);
        do_wr(16'h4000, 8'h01);
        do_rd(16'h4000, v); check("R6 ram mode leaves rom bank", v, exp_rom(3, 16'h4000));
        do_wr(16'hA001, 8'h66);
        do_wr(16'h6000, 8'h00);
        do_rd(16'h4000, v); check("R7 leaving ram mode restores rom upper", v, exp_rom(35, 16'h4000));
        do_rd(16'hA001, v); check("R7 ram bank cleared to 0", v, 8'h01 ^ 8'hA5);
        do_wr(16'h6000, 8'h01);
        do_rd(16'hA001, v); check("R7 ram bank 1 from rom upper", v, 8'h66);

        // ---------------- large-bank variant with clock ----------------
        restart(2'b10, 1'b1);
        do_rd(16'h4000, v); check("R1 large rom bank after reset", v, exp_rom(1, 16'h4000));
        do_wr(16'h2000, 8'h00);
        do_rd(16'h4123, v); check("R4 large bank zero kept", v, exp_rom(0, 16'h4123));
        do_wr(16'h2FFF, 8'h3F);
        do_rd(16'h7FFF, v); check("R4 large bank 0x3F", v, exp_rom(63, 16'h7FFF));
        do_wr(16'h3000, 8'h01);
        do_rd(16'h4000, v); check("R5 bit8 set out of range", v, 8'hFF);
        do_wr(16'h3FFF, 8'h00);
        do_rd(16'h4000, v); check("R5 bit8 cleared", v, exp_rom(63, 16'h4000));

        do_wr(16'h0000, 8'h0A);
        do_wr(16'h4000, 8'h03);
        do_wr(16'hA002, 8'h3C);
        do_rd(16'hA002, v); check("R6 large ram bank 3", v, 8'h3C);
        do_wr(16'h4000, 8'h05);
        do_rd(16'hA002, v); check("R9 ram bank beyond size", v, 8'hFF);
        @(negedge clk); addr = 16'hA002; wdata = 8'h99; wr = 1'b1; #1;
        check("R9 no write strobe beyond size", ram_we, 1'b0);
        @(negedge clk); wr = 1'b0;

        for (int i = 0; i < 5; i++) begin
            logic [7:0] d;
            d = (i == 4) ? 8'hC0 : 8'(8'h40 + i * 3);
            do_wr(16'h4000, 8'(8 + i));
            do_wr(16'hA000, d);
            do_rd(16'hBFFF, v);
            check("R10 clock register readback", v, (i == 4) ? (d | 8'h3E) : d);
        end
        do_wr(16'h0000, 8'h00);
        do_wr(16'h4000, 8'h08);
        do_rd(16'hA000, v); check("R10 clock regs ignore enable", v, 8'h40);
        do_wr(16'h0000, 8'h0A);
        do_wr(16'h4000, 8'h00);
        do_rd(16'hA000, v); check("R10 ram bank 0 untouched", v, 8'hA5);
        do_wr(16'h4000, 8'h03);
        do_rd(16'hA002, v); check("R10 ram bank 3 untouched", v, 8'h3C);

        // ---------------- no controller ----------------
        restart(2'b00, 1'b0);
        do_rd(16'h4000, v); check("R11 linear upper window", v, exp_rom(1, 16'h4000));
        do_wr(16'h2000, 8'h05);
        do_wr(16'h4000, 8'h03);
        do_rd(16'h5ABC, v); check("R11 bank write ignored", v, exp_rom(1, 16'h5ABC));
        do_wr(16'h0000, 8'h0A);
        do_rd(16'hA000, v); check("R11 enable write ignored", v, 8'hFF);
        do_rd(16'h0ABC, v); check("R2 fixed window no controller", v, rom_pat(23'h0ABC));

        restart(2'b11, 1'b0);
        do_wr(16'h2000, 8'h07);
        do_rd(16'h4000, v); check("R3 R11 spare encoding acts as none", v, exp_rom(1, 16'h4000));

        finish_run();
    end

endmodule